// File: doc/BRIEF.md
# Two-Wire Converter Read Slave

This block is a read-only slave on a two-wire serial bus that hands out results from a single-channel converter. A system clock oversamples the bus clock and data lines. From those samples the block finds start, repeated-start and stop conditions, and it compares the first seven bits of each addressed byte against its own address. The top three address bits are fixed at `011`. The lower four come from strap pins.

When the address matches, the slave pulls data low during the ninth clock. After that clock falls it holds the bus clock low and sends a one-cycle start pulse to the converter. It keeps the clock low until the converter returns a done pulse with a 14-bit word. The result then goes out most significant bit first, as two bytes. The second byte ends in two sub-bits that are always zero. If the master acknowledges the second byte, the slave starts another conversion and stretches the clock again. A not-acknowledge frees the bus.

Both bus lines leave the block as active-high pull-down enables. Two pulses tell a power controller when a transaction begins serving, through a match, and when the slave returns to idle.

Top module: `adc_read_slave`

## Requirements
- R1: After reset both pull-down enables are low and the slave is idle. A start is data falling while clock is high; a stop is data rising while clock is high; in idle only a start is acted on.
- R2: The slave drives the acknowledge (data low on the ninth clock) only when received address bits 7..1 equal `011` followed by `addrSel[3:0]`, sent first bit first; a wrong prefix or wrong pin value gets no acknowledge.
- R3: Bit 0 of the address byte (the direction bit) has no effect: both values are acknowledged and served alike.
- R4: After a non-matching address the data line stays released for all further clocks, and no conversion starts until the next start condition.
- R5: On the clock fall that ends the address acknowledge, the slave asserts `convStart` for one cycle and holds the clock low until one cycle after `convDone`.
- R6: The first result byte is D13..D6, most significant bit first.
- R7: The second result byte is D5..D0 followed by two zero sub-bits.
- R8: A master acknowledge after the first byte continues with the second byte. A master acknowledge after the second byte starts a new conversion with a stretched clock, and the next two bytes carry the new result.
- R9: A master not-acknowledge releases both lines, pulses `sleepPulse` once, and leaves the slave deaf to clocks until the next start.
- R10: A stop in the middle of a byte returns the slave to idle. A repeated start in the middle of a byte restarts address reception from bit 7.
- R11: The slave changes its data drive only while the sampled clock is low.
- R12: `wakePulse` fires exactly once for each matched address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Sensed level of the bus clock line |
| sdaIn | input | 1 | Sensed level of the bus data line |
| addrSel | input | 4 | Strap pins giving the low four address bits |
| convDone | input | 1 | One-cycle pulse from the converter when a result is ready |
| convData | input | 14 | Converter result, valid with `convDone` |
| sclLowEn | output | 1 | Pull the bus clock line low (stretching) |
| sdaLowEn | output | 1 | Pull the bus data line low |
| convStart | output | 1 | One-cycle request to start a conversion |
| wakePulse | output | 1 | One-cycle pulse on an address match |
| sleepPulse | output | 1 | One-cycle pulse when the slave returns to idle |

## Verification
The address decoder is tried with every low nibble, including both direction-bit values, against four strap settings. This separates a true match from off-by-one pin values, and a ignored direction bit from one that is wrongly compared. Addresses with wrong fixed prefixes confirm that the upper bits take part in the comparison. Matched reads take two back-to-back conversions whose results include all zeros, all ones and alternating patterns, so a swapped byte, a shifted bit or a nonzero sub-bit shows up at once. Separate sequences abort mid-address with a stop, restart with a repeated start, and end early with a not-acknowledge after the first byte. These show that the slave releases the bus and ignores stray clocks afterwards.

// File: rtl/adc_slave_pkg.sv
package adc_slave_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK,
    ST_CONV,
    ST_RELEASE,
    ST_DATA,
    ST_MACK,
    ST_SKIP
  } slaveState_t;

  // control -> datapath
  typedef struct packed {
    logic rxShift;
    logic txLoad;
    logic txShift;
    logic ackSample;
  } dpStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic sclRise;
    logic sclFall;
    logic startSeen;
    logic stopSeen;
    logic sclLevel;
    logic addrHit;
    logic txBit;
    logic masterAck;
  } dpFlag_t;

endpackage

// File: rtl/adc_slave_datapath.sv
module adc_slave_datapath
  import adc_slave_pkg::*;
#(
  parameter int DATA_W = 14,
  parameter int SUB_W = 2,
  parameter int PIN_W = 4,
  parameter logic [6:0] ADDR_BASE = 7'b0110000,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [PIN_W-1:0]  addrSel,
  input  logic [DATA_W-1:0] convData,
  input  dpStrobe_t         strobe,
  output dpFlag_t           flag
);

  localparam int TX_W = DATA_W + SUB_W;

  logic [SYNC_STAGES-1:0] sclPipe, sdaPipe;
  logic sclPrev, sdaPrev;
  logic sclNow, sdaNow;
  logic [6:0] rxReg;
  logic [TX_W-1:0] txReg;
  logic ackReg;

  assign sclNow = sclPipe[SYNC_STAGES-1];
  assign sdaNow = sdaPipe[SYNC_STAGES-1];

  // line synchronisers plus one history stage for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[SYNC_STAGES-2:0], sclIn};
      sdaPipe <= {sdaPipe[SYNC_STAGES-2:0], sdaIn};
      sclPrev <= sclNow;
      sdaPrev <= sdaNow;
    end
  end

  // address receive register (first seven bits only)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rxReg <= '0;
    else if (strobe.rxShift) rxReg <= {rxReg[5:0], sdaNow};
  end

  // result serialiser: both bytes come out of one load
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) txReg <= '1;
    else if (strobe.txLoad) txReg <= {convData, {SUB_W{1'b0}}};
    else if (strobe.txShift) txReg <= {txReg[TX_W-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ackReg <= 1'b0;
    else if (strobe.ackSample) ackReg <= ~sdaNow;
  end

  always_comb begin
    flag.sclRise   = sclNow & ~sclPrev;
    flag.sclFall   = ~sclNow & sclPrev;
    flag.startSeen = sclNow & sclPrev & sdaPrev & ~sdaNow;
    flag.stopSeen  = sclNow & sclPrev & ~sdaPrev & sdaNow;
    flag.sclLevel  = sclNow;
    flag.addrHit   = (rxReg[6:PIN_W] == ADDR_BASE[6:PIN_W]) && (rxReg[PIN_W-1:0] == addrSel);
    flag.txBit     = txReg[TX_W-1];
    flag.masterAck = ackReg;
  end

  // R7: trailing sub-bits are zero right after a load
  assert_sub_zero_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.txLoad |=> txReg[SUB_W-1:0] == '0);

endmodule

// File: rtl/adc_slave_control.sv
module adc_slave_control
  import adc_slave_pkg::*;
#(
  parameter int BYTE_BITS = 8,
  parameter int N_BYTES = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  dpFlag_t   flag,
  input  logic      convDone,
  output dpStrobe_t strobe,
  output logic      sdaLowEn,
  output logic      sclLowEn,
  output logic      convStart,
  output logic      wakePulse,
  output logic      sleepPulse
);

  localparam int CNT_W = $clog2(BYTE_BITS + 1);
  localparam int BIDX_W = $clog2(N_BYTES + 1);

  slaveState_t state, nxt;
  logic [CNT_W-1:0] bitCnt;
  logic [BIDX_W-1:0] byteCnt;
  logic startConv, countBit;

  always_comb begin
    nxt = state;
    strobe = '0;
    startConv = 1'b0;
    countBit = 1'b0;
    if (flag.startSeen) begin
      nxt = ST_ADDR;
    end else if (flag.stopSeen) begin
      nxt = ST_IDLE;
    end else begin
      case (state)
        ST_ADDR: begin
          if (flag.sclRise && bitCnt < CNT_W'(BYTE_BITS)) begin
            countBit = 1'b1;
            strobe.rxShift = (bitCnt < CNT_W'(BYTE_BITS - 1));
          end
          if (flag.sclFall && bitCnt == CNT_W'(BYTE_BITS))
            nxt = flag.addrHit ? ST_ACK : ST_SKIP;
        end
        ST_ACK: begin
          if (flag.sclFall) begin
            nxt = ST_CONV;
            startConv = 1'b1;
          end
        end
        ST_CONV: begin
          if (convDone) begin
            strobe.txLoad = 1'b1;
            nxt = ST_RELEASE;
          end
        end
        ST_RELEASE: nxt = ST_DATA;
        ST_DATA: begin
          if (flag.sclFall) begin
            strobe.txShift = 1'b1;
            countBit = 1'b1;
            if (bitCnt == CNT_W'(BYTE_BITS - 1)) nxt = ST_MACK;
          end
        end
        ST_MACK: begin
          strobe.ackSample = flag.sclRise;
          if (flag.sclFall) begin
            if (!flag.masterAck) begin
              nxt = ST_IDLE;
            end else if (byteCnt == BIDX_W'(N_BYTES - 1)) begin
              nxt = ST_CONV;
              startConv = 1'b1;
            end else begin
              nxt = ST_DATA;
            end
          end
        end
        default: nxt = state;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      bitCnt     <= '0;
      byteCnt    <= '0;
      convStart  <= 1'b0;
      wakePulse  <= 1'b0;
      sleepPulse <= 1'b0;
    end else begin
      state <= nxt;
      if (flag.startSeen || nxt != state) bitCnt <= '0;
      else if (countBit) bitCnt <= bitCnt + 1'b1;
      if (startConv) byteCnt <= '0;
      else if (state == ST_MACK && nxt == ST_DATA) byteCnt <= byteCnt + 1'b1;
      convStart  <= startConv;
      wakePulse  <= (state == ST_ADDR) && (nxt == ST_ACK);
      sleepPulse <= (state != ST_IDLE) && (nxt == ST_IDLE);
    end
  end

  assign sclLowEn = (state == ST_CONV) || (state == ST_RELEASE);
  assign sdaLowEn = (state == ST_ACK) ||
                    (((state == ST_RELEASE) || (state == ST_DATA)) && !flag.txBit);

  assert_conv_stretch_R5: assert property (@(posedge clk) disable iff (!rstN)
    convStart |-> sclLowEn);

  assert_conv_single_R5: assert property (@(posedge clk) disable iff (!rstN)
    convStart |=> !convStart);

  assert_sda_quiet_R11: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaLowEn) |-> !flag.sclLevel);

  assert_bit_range_R2: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= CNT_W'(BYTE_BITS));

  assert_wake_ack_R12: assert property (@(posedge clk) disable iff (!rstN)
    wakePulse |-> sdaLowEn);

  assert_sleep_free_R9: assert property (@(posedge clk) disable iff (!rstN)
    sleepPulse |-> (!sdaLowEn && !sclLowEn));

endmodule

// File: rtl/adc_read_slave.sv
module adc_read_slave
  import adc_slave_pkg::*;
#(
  parameter int DATA_W = 14,
  parameter int SUB_W = 2,
  parameter int PIN_W = 4,
  parameter logic [6:0] ADDR_BASE = 7'b0110000,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [PIN_W-1:0]  addrSel,
  input  logic              convDone,
  input  logic [DATA_W-1:0] convData,
  output logic              sclLowEn,
  output logic              sdaLowEn,
  output logic              convStart,
  output logic              wakePulse,
  output logic              sleepPulse
);

  localparam int BYTE_BITS = 8;
  localparam int N_BYTES = (DATA_W + SUB_W) / BYTE_BITS;

  dpStrobe_t strobe;
  dpFlag_t flag;

  adc_slave_datapath #(
    .DATA_W(DATA_W), .SUB_W(SUB_W), .PIN_W(PIN_W),
    .ADDR_BASE(ADDR_BASE), .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .addrSel(addrSel), .convData(convData), .strobe(strobe), .flag(flag)
  );

  adc_slave_control #(
    .BYTE_BITS(BYTE_BITS), .N_BYTES(N_BYTES)
  ) u_ctl (
    .clk(clk), .rstN(rstN), .flag(flag), .convDone(convDone),
    .strobe(strobe), .sdaLowEn(sdaLowEn), .sclLowEn(sclLowEn),
    .convStart(convStart), .wakePulse(wakePulse), .sleepPulse(sleepPulse)
  );

endmodule

// File: tb/adc_read_slave_test.sv
module adc_read_slave_test;

  localparam int H = 8;
  localparam int CONV_CYC = 40;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1, sdaM = 1'b1;
  logic [3:0] addrSel = 4'd0;
  logic convDone = 1'b0;
  logic [13:0] convData = '0;
  logic sclLowEn, sdaLowEn, convStart, wakePulse, sleepPulse;
  logic sclLine, sdaLine;

  int compared = 0, mismatched = 0;
  int convIssued = 0, wakeCnt = 0, sleepCnt = 0, expNum = 0;
  bit finished = 0;

  assign sclLine = sclM & ~sclLowEn;
  assign sdaLine = sdaM & ~sdaLowEn;

  always #5 clk = ~clk;

  adc_read_slave uut (
    .clk(clk), .rstN(rstN), .sclIn(sclLine), .sdaIn(sdaLine),
    .addrSel(addrSel), .convDone(convDone), .convData(convData),
    .sclLowEn(sclLowEn), .sdaLowEn(sdaLowEn), .convStart(convStart),
    .wakePulse(wakePulse), .sleepPulse(sleepPulse)
  );

  function automatic logic [13:0] dataFor(input int n);
    case (n)
      0: return 14'h0000;
      1: return 14'h3FFF;
      2: return 14'h2AAA;
      3: return 14'h1555;
      default: return 14'((n * 4919 + 341) & 16'h3FFF);
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sclHigh();
    sclM = 1'b1;
    @(negedge clk);
    while (!sclLine) @(negedge clk);
  endtask

  task automatic writeBit(input logic b);
    sdaM = b;
    waitCyc(H);
    sclHigh();
    waitCyc(H);
    sclM = 1'b0;
    waitCyc(2);
  endtask

  task automatic readBit(output logic b);
    sdaM = 1'b1;
    waitCyc(H);
    sclHigh();
    waitCyc(H / 2);
    b = sdaLine;
    waitCyc(H / 2);
    sclM = 1'b0;
    waitCyc(2);
  endtask

  task automatic masterStart();
    sdaM = 1'b1; sclM = 1'b1;
    waitCyc(H);
    sdaM = 1'b0;
    waitCyc(H);
    sclM = 1'b0;
    waitCyc(H);
  endtask

  task automatic repStart();
    sdaM = 1'b1;
    waitCyc(H);
    sclHigh();
    waitCyc(H);
    sdaM = 1'b0;
    waitCyc(H);
    sclM = 1'b0;
    waitCyc(H);
  endtask

  task automatic masterStop();
    sdaM = 1'b0;
    waitCyc(H);
    sclHigh();
    waitCyc(H);
    sdaM = 1'b1;
    waitCyc(H);
  endtask

  task automatic writeBits(input logic [7:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) writeBit(v[i]);
  endtask

  task automatic writeByte(input logic [7:0] v, output logic ack);
    writeBits(v, 8);
    readBit(ack);
  endtask

  task automatic readByte(output logic [7:0] v, input logic nack);
    for (int i = 7; i >= 0; i--) begin
      logic b;
      readBit(b);
      v[i] = b;
    end
    writeBit(nack);
  endtask

  // converter model
  initial begin
    forever begin
      @(negedge clk);
      if (convStart) begin
        waitCyc(CONV_CYC / 2);
        check(sclLine == 1'b0, "R5 clock held during conversion", int'(sclLine), 0);
        waitCyc(CONV_CYC / 2);
        convData = dataFor(convIssued);
        convIssued++;
        convDone = 1'b1;
        @(negedge clk);
        convDone = 1'b0;
      end
    end
  end

  // pulse monitors
  initial begin
    forever begin
      @(negedge clk);
      if (wakePulse) wakeCnt++;
      if (sleepPulse) sleepCnt++;
    end
  end

  // watchdog
  initial begin
    waitCyc(150000);
    if (!finished) begin
      finished = 1;
      compared++;
      mismatched++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic ack;
    logic [7:0] b1, b2;
    logic [13:0] d;
    int wakeBefore, convBefore, sleepBefore;

    waitCyc(5);
    rstN = 1'b1;
    waitCyc(3);
    check(sdaLowEn == 1'b0, "R1 data released after reset", int'(sdaLowEn), 0);
    check(sclLowEn == 1'b0, "R1 clock released after reset", int'(sclLowEn), 0);
    check(convStart == 1'b0, "R1 no conversion after reset", int'(convStart), 0);

    // address sweep over strap settings and every low nibble
    for (int p = 0; p < 16; p += 5) begin
      addrSel = 4'(p);
      for (int low = 0; low < 16; low++) begin
        logic rw;
        rw = logic'(low & 1);
        wakeBefore = wakeCnt;
        convBefore = convIssued;
        masterStart();
        writeByte({3'b011, 4'(low), rw}, ack);
        if (low == p) begin
          check(ack == 1'b0, "R2 R3 matched address acknowledged", int'(ack), 0);
          check(wakeCnt == wakeBefore + 1, "R12 one wake pulse", wakeCnt, wakeBefore + 1);
          for (int k = 0; k < 2; k++) begin
            d = dataFor(expNum);
            readByte(b1, 1'b0);
            check(b1 == d[13:6], "R6 first byte", b1, d[13:6]);
            readByte(b2, (k == 0) ? 1'b0 : 1'b1);
            check(b2 == {d[5:0], 2'b00}, "R7 second byte", b2, {d[5:0], 2'b00});
            expNum++;
          end
          check(convIssued == convBefore + 2, "R8 repeated conversion", convIssued, convBefore + 2);
        end else begin
          check(ack == 1'b1, "R2 other address ignored", int'(ack), 1);
          readByte(b1, 1'b1);
          check(b1 == 8'hFF, "R4 data stays released", b1, 8'hFF);
          check(convIssued == convBefore, "R4 no conversion", convIssued, convBefore);
        end
        masterStop();
      end
    end

    // wrong fixed prefixes
    addrSel = 4'd9;
    for (int pre = 0; pre < 8; pre++) begin
      if (pre != 3) begin
        masterStart();
        writeByte({3'(pre), 4'd9, 1'b1}, ack);
        check(ack == 1'b1, "R2 wrong prefix ignored", int'(ack), 1);
        masterStop();
      end
    end

    // not-acknowledge after the first byte
    sleepBefore = sleepCnt;
    masterStart();
    writeByte({3'b011, 4'd9, 1'b0}, ack);
    check(ack == 1'b0, "R2 match before early end", int'(ack), 0);
    d = dataFor(expNum);
    readByte(b1, 1'b1);
    expNum++;
    check(b1 == d[13:6], "R6 first byte before early end", b1, d[13:6]);
    waitCyc(4);
    check(sleepCnt == sleepBefore + 1, "R9 sleep pulse", sleepCnt, sleepBefore + 1);
    check(sdaLowEn == 1'b0 && sclLowEn == 1'b0, "R9 bus released", int'({sdaLowEn, sclLowEn}), 0);
    convBefore = convIssued;
    readByte(b1, 1'b0);
    check(b1 == 8'hFF, "R9 stray clocks ignored", b1, 8'hFF);
    check(convIssued == convBefore, "R9 no conversion after release", convIssued, convBefore);
    masterStop();

    // stop in the middle of the address
    convBefore = convIssued;
    masterStart();
    writeBits(8'b0000_0110, 4);
    masterStop();
    writeBits(8'b1001_0000, 4);
    readByte(b1, 1'b0);
    check(b1 == 8'hFF, "R10 idle after mid-byte stop", b1, 8'hFF);
    check(convIssued == convBefore, "R10 no conversion after abort", convIssued, convBefore);
    masterStop();

    // repeated start in the middle of the address
    masterStart();
    writeBits(8'b0000_0011, 3);
    repStart();
    writeByte({3'b011, 4'd9, 1'b1}, ack);
    check(ack == 1'b0, "R10 address restarted", int'(ack), 0);
    d = dataFor(expNum);
    readByte(b1, 1'b1);
    expNum++;
    check(b1 == d[13:6], "R10 R6 byte after restart", b1, d[13:6]);
    masterStop();

    // repeated start after a non-matching address
    masterStart();
    writeByte({3'b011, 4'd8, 1'b1}, ack);
    check(ack == 1'b1, "R4 neighbour address ignored", int'(ack), 1);
    repStart();
    writeByte({3'b011, 4'd9, 1'b0}, ack);
    check(ack == 1'b0, "R4 served after next start", int'(ack), 0);
    d = dataFor(expNum);
    readByte(b1, 1'b0);
    check(b1 == d[13:6], "R6 byte after skip", b1, d[13:6]);
    readByte(b2, 1'b1);
    check(b2 == {d[5:0], 2'b00}, "R7 byte after skip", b2, {d[5:0], 2'b00});
    expNum++;
    masterStop();

    waitCyc(10);
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule